// File: doc/BRIEF.md
# LVDS Lane and Colour Swap Router

This block sits between a pixel pipeline and an LVDS serializer. Each clock it takes one odd pixel and one even pixel as RGB words, plus a colour depth code. It builds the logical lane words for two output links, port A and port B. A single configuration word controls all the remappings that board layouts and panels commonly need:
- red/blue, red/green and green/blue exchanges, chosen separately for odd and even pixels;
- a mirrored reorder of the lanes that includes the clock lane;
- a differential polarity flag on every lane;
- dual-port operation, and the exchange of the two links.

Every output is registered. A change to the pixels or to the configuration appears on the outputs one clock later. The downstream serializer takes each slot's data word and its P/M flag. The flag tells it to exchange the two legs of that pair.

Top module: `lvds_swap_router`

## Requirements
- R1: While rst_n is low, every data word and every polarity flag on both ports is zero.
- R2: Outputs are registered. The values applied before a rising edge appear right after that edge, and back-to-back changes are followed cycle by cycle.
- R3: Pixel fields are R = bits 29:20, G = bits 19:10, B = bits 9:0. Lane words are 6 bits wide:
  - CH0 = R[9:4], CH1 = G[9:4], CH2 = B[9:4];
  - CH3 = {R[3:2],G[3:2],B[3:2]};
  - CH4 = {R[1:0],G[1:0],B[1:0]}.
- R4: Slot i of a port occupies data bits [6i+5:6i]. The depth code sets the natural slot order:
  - code 0 (6 bit): slots 0..3 carry CH0, CH1, CH2, CLK;
  - code 1 (8 bit): adds CH3 in slot 4;
  - codes 2 and 3 (10 bit): also add CH4 in slot 5.
  The clock lane word is 6'b111000. Slots beyond the active count are zero.
- R5: With cfg bit 9 set, the active slots are mirrored: slot i takes the lane of slot N-1-i, where N is 4, 5 or 6 active slots. At 8 bit this exchanges CH0 with CH3 and CH1 with CLK, and leaves CH2 in place.
- R6: With cfg bit 8 set, the polarity flag is 1 on every active slot, the clock slot included, and 0 on inactive slots. Data words are unchanged. With bit 8 clear, all flags are 0.
- R7: Colour exchanges are applied in this order: red/blue, then red/green, then green/blue. The enable bits are:
  - odd pixel: red/blue bit 0, green/blue bit 2, red/green bit 3;
  - even pixel: red/blue bit 1, green/blue bit 4, red/green bit 5.
  The odd bits affect only the odd pixel, and the even bits affect only the even pixel.
- R8: With cfg bit 6 (dual port) set, port A carries the odd pixel and port B carries the even pixel. With bit 6 clear, port A carries the odd pixel and port B data and flags are all zero.
- R9: In dual-port mode, cfg bit 7 exchanges the links: port A carries the even pixel and port B the odd pixel. In single-port mode, bit 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| odd_pix | input | 30 | Odd pixel, {R,G,B} with 10 bits each |
| even_pix | input | 30 | Even pixel, {R,G,B} with 10 bits each |
| depth_sel | input | 2 | Colour depth code: 0 = 6 bit, 1 = 8 bit, 2 or 3 = 10 bit |
| cfg | input | 10 | Configuration bits, as listed in R5 to R9 |
| a_lane_data | output | 36 | Port A, six 6-bit slot words |
| a_lane_pol | output | 6 | Port A, P/M exchange flag per slot |
| b_lane_data | output | 36 | Port B, six 6-bit slot words |
| b_lane_pol | output | 6 | Port B, P/M exchange flag per slot |

## Verification
The assertions assume that the pixels, the depth code and the configuration word hold known values at every rising edge. They also assume these inputs are sampled once per cycle. On that basis each registered output can be related to the inputs one edge earlier.

The stimulus changes inputs only on falling clock edges and keeps them at defined values during and after reset. Every test vector uses only the defined configuration bits. The reserved depth code 3 is driven on purpose, so that its 10-bit behaviour is covered within these assumptions.

// File: rtl/lvds_router_pkg.sv
package lvds_router_pkg;
  localparam int COLOR_W   = 10;
  localparam int PIX_W     = 3 * COLOR_W;
  localparam int LANE_W    = COLOR_W - 4;
  localparam int NUM_CH    = 5;
  localparam int MAX_SLOTS = NUM_CH + 1;
  localparam int SLOT_BITS = MAX_SLOTS * LANE_W;
  localparam int SW        = $clog2(MAX_SLOTS + 1);
  localparam int CFG_W     = 10;

  localparam logic [LANE_W-1:0] CLK_PAT =
    {{(LANE_W/2){1'b1}}, {(LANE_W - LANE_W/2){1'b0}}};

  // configuration bit positions
  localparam int CFG_ODD_RB  = 0;
  localparam int CFG_EVEN_RB = 1;
  localparam int CFG_ODD_GB  = 2;
  localparam int CFG_ODD_RG  = 3;
  localparam int CFG_EVEN_GB = 4;
  localparam int CFG_EVEN_RG = 5;
  localparam int CFG_DUAL    = 6;
  localparam int CFG_PSWAP   = 7;
  localparam int CFG_POL     = 8;
  localparam int CFG_LSWAP   = 9;

  typedef enum logic [1:0] {
    DEPTH_6   = 2'd0,
    DEPTH_8   = 2'd1,
    DEPTH_10  = 2'd2,
    DEPTH_10X = 2'd3
  } depth_e;

  function automatic logic [COLOR_W+1:0] colour_sum(input logic [PIX_W-1:0] p);
    return {2'b00, p[PIX_W-1 -: COLOR_W]} + {2'b00, p[2*COLOR_W-1 -: COLOR_W]}
         + {2'b00, p[COLOR_W-1:0]};
  endfunction
endpackage

// File: rtl/colour_swap.sv
module colour_swap
  import lvds_router_pkg::*;
(
  input  logic [PIX_W-1:0] pix_in,
  input  logic             en_rb,
  input  logic             en_rg,
  input  logic             en_gb,
  output logic [PIX_W-1:0] pix_out
);
  logic [COLOR_W-1:0] r0, g0, b0;
  logic [COLOR_W-1:0] r1, b1;
  logic [COLOR_W-1:0] r2, g2;
  logic [COLOR_W-1:0] g3, b3;

  always_comb begin
    r0 = pix_in[PIX_W-1 -: COLOR_W];
    g0 = pix_in[2*COLOR_W-1 -: COLOR_W];
    b0 = pix_in[COLOR_W-1:0];
    // stage 1: red/blue
    r1 = en_rb ? b0 : r0;
    b1 = en_rb ? r0 : b0;
    // stage 2: red/green
    r2 = en_rg ? g0 : r1;
    g2 = en_rg ? r1 : g0;
    // stage 3: green/blue
    g3 = en_gb ? b1 : g2;
    b3 = en_gb ? g2 : b1;
    pix_out = {r2, g3, b3};
  end
endmodule

// File: rtl/lane_pack.sv
module lane_pack
  import lvds_router_pkg::*;
(
  input  logic [PIX_W-1:0]         pix,
  output logic [NUM_CH*LANE_W-1:0] ch_flat
);
  logic [COLOR_W-1:0] r, g, b;

  always_comb begin
    r = pix[PIX_W-1 -: COLOR_W];
    g = pix[2*COLOR_W-1 -: COLOR_W];
    b = pix[COLOR_W-1:0];
    ch_flat = '0;
    ch_flat[0*LANE_W +: LANE_W] = r[COLOR_W-1:4];
    ch_flat[1*LANE_W +: LANE_W] = g[COLOR_W-1:4];
    ch_flat[2*LANE_W +: LANE_W] = b[COLOR_W-1:4];
    ch_flat[3*LANE_W +: LANE_W] = {r[3:2], g[3:2], b[3:2]};
    ch_flat[4*LANE_W +: LANE_W] = {r[1:0], g[1:0], b[1:0]};
  end
endmodule

// File: rtl/lane_order.sv
module lane_order
  import lvds_router_pkg::*;
(
  input  logic [NUM_CH*LANE_W-1:0] ch_flat,
  input  logic [1:0]               depth,
  input  logic                     lane_swap,
  input  logic                     pol_swap,
  output logic [SLOT_BITS-1:0]     slot_data,
  output logic [MAX_SLOTS-1:0]     slot_pol
);
  logic [LANE_W-1:0] nat [MAX_SLOTS];
  logic [SW-1:0]     active;

  // natural order: CH0 CH1 CH2 CLK CH3 CH4
  always_comb begin
    nat[0] = ch_flat[0*LANE_W +: LANE_W];
    nat[1] = ch_flat[1*LANE_W +: LANE_W];
    nat[2] = ch_flat[2*LANE_W +: LANE_W];
    nat[3] = CLK_PAT;
    nat[4] = ch_flat[3*LANE_W +: LANE_W];
    nat[5] = ch_flat[4*LANE_W +: LANE_W];
  end

  always_comb begin
    case (depth_e'(depth))
      DEPTH_6: active = SW'(MAX_SLOTS - 2);
      DEPTH_8: active = SW'(MAX_SLOTS - 1);
      default: active = SW'(MAX_SLOTS);
    endcase
  end

  for (genvar i = 0; i < MAX_SLOTS; i++) begin : g_slot
    logic [SW-1:0] src;
    always_comb begin
      src = lane_swap ? SW'(active - SW'(1) - SW'(i)) : SW'(i);
      if (SW'(i) < active) begin
        slot_data[i*LANE_W +: LANE_W] = nat[src];
        slot_pol[i]                   = pol_swap;
      end else begin
        slot_data[i*LANE_W +: LANE_W] = '0;
        slot_pol[i]                   = 1'b0;
      end
    end
  end
endmodule

// File: rtl/lvds_swap_router.sv
module lvds_swap_router
  import lvds_router_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIX_W-1:0]     odd_pix,
  input  logic [PIX_W-1:0]     even_pix,
  input  logic [1:0]           depth_sel,
  input  logic [CFG_W-1:0]     cfg,
  output logic [SLOT_BITS-1:0] a_lane_data,
  output logic [MAX_SLOTS-1:0] a_lane_pol,
  output logic [SLOT_BITS-1:0] b_lane_data,
  output logic [MAX_SLOTS-1:0] b_lane_pol
);
  localparam int NPATH = 2;

  logic [PIX_W-1:0]         path_in  [NPATH];
  logic [PIX_W-1:0]         path_cs  [NPATH];
  logic [NUM_CH*LANE_W-1:0] path_ch  [NPATH];
  logic [SLOT_BITS-1:0]     path_dat [NPATH];
  logic [MAX_SLOTS-1:0]     path_pol [NPATH];

  assign path_in[0] = odd_pix;
  assign path_in[1] = even_pix;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    localparam int RB_BIT = (p == 0) ? CFG_ODD_RB : CFG_EVEN_RB;
    localparam int RG_BIT = (p == 0) ? CFG_ODD_RG : CFG_EVEN_RG;
    localparam int GB_BIT = (p == 0) ? CFG_ODD_GB : CFG_EVEN_GB;

    colour_swap u_cs (
      .pix_in  (path_in[p]),
      .en_rb   (cfg[RB_BIT]),
      .en_rg   (cfg[RG_BIT]),
      .en_gb   (cfg[GB_BIT]),
      .pix_out (path_cs[p])
    );

    lane_pack u_pack (
      .pix     (path_cs[p]),
      .ch_flat (path_ch[p])
    );

    lane_order u_order (
      .ch_flat   (path_ch[p]),
      .depth     (depth_sel),
      .lane_swap (cfg[CFG_LSWAP]),
      .pol_swap  (cfg[CFG_POL]),
      .slot_data (path_dat[p]),
      .slot_pol  (path_pol[p])
    );

    // colour exchange is a permutation: the sum of the three fields is kept
    AST_COLOUR_PERM: assert property (@(posedge clk) disable iff (!rst_n)
      colour_sum(path_in[p]) == colour_sum(path_cs[p])); // R7
  end

  // next-state for port routing
  logic [SLOT_BITS-1:0] a_dat_d, b_dat_d, a_dat_q, b_dat_q;
  logic [MAX_SLOTS-1:0] a_pol_d, b_pol_d, a_pol_q, b_pol_q;

  always_comb begin
    a_dat_d = path_dat[0];
    a_pol_d = path_pol[0];
    b_dat_d = '0;
    b_pol_d = '0;
    if (cfg[CFG_DUAL]) begin
      if (cfg[CFG_PSWAP]) begin
        a_dat_d = path_dat[1];
        a_pol_d = path_pol[1];
        b_dat_d = path_dat[0];
        b_pol_d = path_pol[0];
      end else begin
        b_dat_d = path_dat[1];
        b_pol_d = path_pol[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_dat_q <= '0;
      a_pol_q <= '0;
      b_dat_q <= '0;
      b_pol_q <= '0;
    end else begin
      a_dat_q <= a_dat_d;
      a_pol_q <= a_pol_d;
      b_dat_q <= b_dat_d;
      b_pol_q <= b_pol_d;
    end
  end

  assign a_lane_data = a_dat_q;
  assign a_lane_pol  = a_pol_q;
  assign b_lane_data = b_dat_q;
  assign b_lane_pol  = b_pol_q;

  AST_SINGLE_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[CFG_DUAL] |=> (b_lane_data == '0 && b_lane_pol == '0)); // R8

  AST_POL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[CFG_POL] |=> (a_lane_pol == '0 && b_lane_pol == '0)); // R6

  AST_POL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[CFG_POL] && depth_sel == DEPTH_8) |=> $countones(a_lane_pol) == MAX_SLOTS - 1); // R6

  AST_SHORT_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_sel == DEPTH_6) |=> a_lane_data[SLOT_BITS-1 -: 2*LANE_W] == '0); // R4

  AST_CLK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_sel == DEPTH_6 && !cfg[CFG_LSWAP]) |=> a_lane_data[3*LANE_W +: LANE_W] == CLK_PAT); // R4
endmodule

// File: tb/lvds_swap_router_test.sv
module lvds_swap_router_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] odd_pix = '0, even_pix = '0;
  logic [1:0]  depth_sel = '0;
  logic [9:0]  cfg = '0;
  logic [35:0] a_lane_data, b_lane_data;
  logic [5:0]  a_lane_pol, b_lane_pol;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  lvds_swap_router uut (
    .clk(clk), .rst_n(rst_n), .odd_pix(odd_pix), .even_pix(even_pix),
    .depth_sel(depth_sel), .cfg(cfg),
    .a_lane_data(a_lane_data), .a_lane_pol(a_lane_pol),
    .b_lane_data(b_lane_data), .b_lane_pol(b_lane_pol)
  );

  typedef struct {
    logic [35:0] ad;
    logic [5:0]  ap;
    logic [35:0] bd;
    logic [5:0]  bp;
    string       tag;
  } exp_t;

  typedef struct {
    logic [35:0] d;
    logic [5:0]  p;
  } port_t;

  exp_t sb[$];

  function automatic logic [29:0] m_swap(input logic [29:0] x, input bit rb, rg, gb);
    logic [9:0] r, g, b, t;
    r = x[29:20]; g = x[19:10]; b = x[9:0];
    if (rb) begin t = r; r = b; b = t; end
    if (rg) begin t = r; r = g; g = t; end
    if (gb) begin t = g; g = b; b = t; end
    return {r, g, b};
  endfunction

  function automatic port_t m_port(input logic [29:0] x, input logic [1:0] d, input bit ls, ps);
    port_t o;
    logic [5:0] lane [6];
    int n;
    lane[0] = x[29:24];
    lane[1] = x[19:14];
    lane[2] = x[9:4];
    lane[3] = 6'b111000;
    lane[4] = {x[23:22], x[13:12], x[3:2]};
    lane[5] = {x[21:20], x[11:10], x[1:0]};
    n = (d == 2'd0) ? 4 : (d == 2'd1) ? 5 : 6;
    o.d = '0;
    o.p = '0;
    for (int i = 0; i < n; i++) begin
      o.d[i*6 +: 6] = ls ? lane[n-1-i] : lane[i];
      o.p[i] = ps;
    end
    return o;
  endfunction

  task automatic send(input logic [29:0] o, e, input logic [1:0] d, input logic [9:0] c,
                      input string tag);
    exp_t  x;
    port_t po, pe;
    @(negedge clk);
    odd_pix = o; even_pix = e; depth_sel = d; cfg = c;
    po = m_port(m_swap(o, c[0], c[3], c[2]), d, c[9], c[8]);
    pe = m_port(m_swap(e, c[1], c[5], c[4]), d, c[9], c[8]);
    x.tag = tag;
    x.ad = po.d; x.ap = po.p; x.bd = '0; x.bp = '0;
    if (c[6]) begin
      if (c[7]) begin
        x.ad = pe.d; x.ap = pe.p; x.bd = po.d; x.bp = po.p;
      end else begin
        x.bd = pe.d; x.bp = pe.p;
      end
    end
    sb.push_back(x);
  endtask

  // monitor: compares just after each capturing edge
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t x;
      x = sb.pop_front();
      checks++;
      if (a_lane_data !== x.ad || a_lane_pol !== x.ap ||
          b_lane_data !== x.bd || b_lane_pol !== x.bp) begin
        errors++;
        $display("FAIL %s: got A=%h/%b B=%h/%b expected A=%h/%b B=%h/%b", x.tag,
                 a_lane_data, a_lane_pol, b_lane_data, b_lane_pol,
                 x.ad, x.ap, x.bd, x.bp);
      end
    end
  end

  localparam logic [29:0] PO = {10'h3A5, 10'h1C6, 10'h0F9};
  localparam logic [29:0] PE = {10'h25A, 10'h3C3, 10'h10E};

  initial begin
    odd_pix = PO; even_pix = PE; depth_sel = 2'd2; cfg = 10'h3FF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (a_lane_data !== '0 || a_lane_pol !== '0 || b_lane_data !== '0 || b_lane_pol !== '0) begin
      errors++;
      $display("FAIL R1: got A=%h/%b B=%h/%b expected all zero",
               a_lane_data, a_lane_pol, b_lane_data, b_lane_pol);
    end
    rst_n = 1'b1;

    send(PO, PE, 2'd1, 10'h040, "R3 packing 8 bit dual");
    send(PO, PE, 2'd0, 10'h040, "R4 order 6 bit");
    send(PO, PE, 2'd2, 10'h040, "R4 order 10 bit");
    send(PO, PE, 2'd3, 10'h040, "R4 order code 3");
    send(PO, PE, 2'd0, 10'h240, "R5 mirror 6 bit");
    send(PO, PE, 2'd1, 10'h240, "R5 mirror 8 bit");
    send(PO, PE, 2'd2, 10'h240, "R5 mirror 10 bit");
    send(PO, PE, 2'd1, 10'h140, "R6 polarity 8 bit");
    send(PO, PE, 2'd2, 10'h340, "R6 polarity with mirror 10 bit");
    send(PO, PE, 2'd0, 10'h100, "R6 polarity single 6 bit");
    send(PO, PE, 2'd2, 10'h041, "R7 odd red/blue");
    send(PO, PE, 2'd2, 10'h042, "R7 even red/blue");
    send(PO, PE, 2'd2, 10'h044, "R7 odd green/blue");
    send(PO, PE, 2'd2, 10'h048, "R7 odd red/green");
    send(PO, PE, 2'd2, 10'h050, "R7 even green/blue");
    send(PO, PE, 2'd2, 10'h060, "R7 even red/green");
    send(PO, PE, 2'd2, 10'h049, "R7 order red/blue then red/green");
    send(PO, PE, 2'd1, 10'h07F, "R7 all exchanges");
    send(PO, PE, 2'd1, 10'h000, "R8 single port");
    send(PO, PE, 2'd1, 10'h0C0, "R9 port exchange dual");
    send(PO, PE, 2'd1, 10'h080, "R9 port exchange ignored single");
    for (int k = 0; k < 6; k++) begin
      send(PO ^ 30'(k * 30'h1234567), PE + 30'(k * 30'h0ABCDEF), 2'(k),
           10'((k * 10'h2B7) & 10'h3FF), "R2 back-to-back updates");
    end
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule